// File: doc/BRIEF.md
# Instruction Cycle-Cost Timer

This block works out how many clock cycles an instruction of a small 8-bit accumulator CPU occupies. It then counts that many cycles out on a busy flag. A controller that already knows the operation class, the addressing mode and the operand addresses presents them together with a one-cycle start strobe. The block returns the cost and holds busy for exactly that many clocks. A done pulse marks the last of those clocks.

The cost depends on the class and on the mode together. Indexed modes that leave page zero pay one extra cycle when the index carries the effective address into another 256-byte page. Stores in those modes always pay that cycle. Read-modify-write operations pay a fixed cost. Taken branches cost one cycle more, and one further cycle when the target lies in another page. A class and mode pair that the CPU cannot issue raises an error flag and costs 2 cycles. The block does no decoding, fetching, memory access or arithmetic on data.

Top module: `cycle_cost_timer`

## Requirements
- R1: Class codes are 0 read/ALU, 1 store, 2 read-modify-write, 3 register-only, 4 push, 5 pull, 6 return, 7 break, 8 branch, 9 jump, 10 call. Mode codes are 0 implied/accumulator, 1 immediate, 2 zero page, 3 zero page+X, 4 zero page+Y, 5 absolute, 6 absolute+X, 7 absolute+Y, 8 pre-indexed indirect, 9 post-indexed indirect, 10 indirect, 11 relative. An unlisted class, or a mode not allowed for the class, sets `mode_err` and gives a cost of 2. A valid pair clears `mode_err`.
- R2: Read/ALU (class 0) accepts modes 1 to 9. Its costs are: immediate 2, zero page 3, zero page indexed 4, absolute 4, absolute indexed 4, pre-indexed indirect 6, post-indexed indirect 5.
- R3: For modes 6, 7 and 9 in class 0, one cycle is added when bits [15:8] of `base_addr` differ from bits [15:8] of (`base_addr` + zero-extended `index`), taken modulo 2^16.
- R4: Store (class 1) accepts modes 2 to 9 and has the same base costs as class 0. Modes 6, 7 and 9 always add one cycle, whether or not a page is crossed.
- R5: Modes 3, 4 and 8 never take a page-cross penalty, whatever the base address and index.
- R6: Read-modify-write (class 2) accepts modes 0, 2, 3, 5 and 6. Its costs are 2, 5, 6, 6 and 7, with no dependence on page crossing.
- R7: Classes 3 to 7 accept only mode 0. They cost 2, 3, 4, 6 and 7 respectively.
- R8: Branch (class 8) accepts only mode 11. It costs 2 when `taken` is low and 3 when `taken` is high. A taken branch costs 4 when bits [15:8] of `target` differ from bits [15:8] of `base_addr`, which holds the address after the branch.
- R9: Jump (class 9) costs 3 in mode 5 and 5 in mode 10. Call (class 10) costs 6 in mode 5.
- R10: When `start` is high and `busy` is low at a clock edge, `cycles` and `mode_err` load from that edge. `busy` is then high for exactly `cycles` clocks, and `done` is high only in the last of them.
- R11: A `start` while `busy` is high is ignored. `cycles`, `mode_err` and the length of the busy run do not change.
- R12: After reset, `busy`, `done`, `cycles` and `mode_err` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch strobe |
| op_cls | input | 4 | Operation class code |
| mode | input | 4 | Addressing-mode code |
| base_addr | input | ADDR_W | Un-indexed address, or the address after a branch |
| index | input | IDX_W | Index register value |
| taken | input | 1 | Branch condition met |
| target | input | ADDR_W | Branch destination |
| cycles | output | CNT_W | Cost of the launched instruction |
| busy | output | 1 | Instruction still occupying cycles |
| done | output | 1 | Last busy cycle |
| mode_err | output | 1 | Invalid class/mode pair launched |

## Verification
The bench uses the default parameters: 16-bit addresses, an 8-bit index, 256-byte pages and a 4-bit counter. With these, a single index addition crosses at most one page boundary, and the wrap from page FF to page 00 is a crossing that can be reached. Every class code from 0 to 15 is paired with every mode from 0 to 15, using both a crossing index and a non-crossing index. This covers all accepted pairs and many rejected ones. A seeded random mix follows, together with directed cases for page boundaries, stores that do not cross, branches inside and across pages, and starts issued during a busy run.

// File: rtl/cycle_cost_timer.sv
module cycle_cost_timer #(
  parameter int ADDR_W = 16,
  parameter int IDX_W  = 8,
  parameter int PAGE_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        op_cls,
  input  logic [3:0]        mode,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [IDX_W-1:0]  index,
  input  logic              taken,
  input  logic [ADDR_W-1:0] target,
  output logic [CNT_W-1:0]  cycles,
  output logic              busy,
  output logic              done,
  output logic              mode_err
);
  localparam logic [3:0] C_READ = 4'd0, C_STORE = 4'd1, C_RMW = 4'd2, C_REG = 4'd3,
                         C_PUSH = 4'd4, C_PULL = 4'd5, C_RET = 4'd6, C_BRK = 4'd7,
                         C_BRANCH = 4'd8, C_JUMP = 4'd9, C_CALL = 4'd10;
  localparam logic [3:0] M_IMP = 4'd0, M_IMM = 4'd1, M_ZP = 4'd2, M_ZPX = 4'd3,
                         M_ZPY = 4'd4, M_ABS = 4'd5, M_ABX = 4'd6, M_ABY = 4'd7,
                         M_INX = 4'd8, M_INY = 4'd9, M_IND = 4'd10, M_REL = 4'd11;
  localparam int PG_HI = ADDR_W - 1;

  logic [ADDR_W-1:0] eff;
  logic              idx_cross, br_cross, is_store, pen;
  logic [CNT_W-1:0]  cost, cnt;
  logic              bad;

  assign eff       = base_addr + ADDR_W'(index);
  assign idx_cross = eff[PG_HI:PAGE_W] != base_addr[PG_HI:PAGE_W];
  assign br_cross  = target[PG_HI:PAGE_W] != base_addr[PG_HI:PAGE_W];
  assign is_store  = op_cls == C_STORE;
  assign pen       = is_store | idx_cross;

  always_comb begin
    cost = CNT_W'(2);
    bad  = 1'b0;
    case (op_cls)
      C_READ, C_STORE:
        case (mode)
          M_IMM:        bad = is_store;
          M_ZP:         cost = CNT_W'(3);
          M_ZPX, M_ZPY,
          M_ABS:        cost = CNT_W'(4);
          M_ABX, M_ABY: cost = CNT_W'(4) + CNT_W'(pen);
          M_INX:        cost = CNT_W'(6);
          M_INY:        cost = CNT_W'(5) + CNT_W'(pen);
          default:      bad = 1'b1;
        endcase
      C_RMW:
        case (mode)
          M_IMP:        cost = CNT_W'(2);
          M_ZP:         cost = CNT_W'(5);
          M_ZPX, M_ABS: cost = CNT_W'(6);
          M_ABX:        cost = CNT_W'(7);
          default:      bad = 1'b1;
        endcase
      C_REG, C_PUSH, C_PULL, C_RET, C_BRK:
        if (mode != M_IMP) bad = 1'b1;
        else
          case (op_cls)
            C_PUSH:  cost = CNT_W'(3);
            C_PULL:  cost = CNT_W'(4);
            C_RET:   cost = CNT_W'(6);
            C_BRK:   cost = CNT_W'(7);
            default: cost = CNT_W'(2);
          endcase
      C_BRANCH:
        if (mode != M_REL) bad = 1'b1;
        else cost = CNT_W'(2) + CNT_W'(taken) + CNT_W'(taken & br_cross);
      C_JUMP:
        if (mode == M_ABS)      cost = CNT_W'(3);
        else if (mode == M_IND) cost = CNT_W'(5);
        else                    bad = 1'b1;
      C_CALL:
        if (mode == M_ABS) cost = CNT_W'(6);
        else               bad = 1'b1;
      default: bad = 1'b1;
    endcase
    if (bad) cost = CNT_W'(2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      cycles   <= '0;
      mode_err <= 1'b0;
    end else if (start && cnt == '0) begin
      cnt      <= cost;
      cycles   <= cost;
      mode_err <= bad;
    end else if (cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign busy = cnt != '0;
  assign done = cnt == CNT_W'(1);
endmodule

// File: rtl/cycle_cost_timer_chk.sv
module cycle_cost_timer_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             mode_err,
  input logic [CNT_W-1:0] cycles
);
  logic [CNT_W-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             run <= '0;
    else if (busy && !done) run <= run + CNT_W'(1);
    else                    run <= '0;
  end

  // R10
  done_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> busy);
  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) busy && !done |=> busy);
  // R10
  done_end_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !busy);
  // R10
  run_len_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> run == cycles - CNT_W'(1));
  // R10
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && cycles >= CNT_W'(2));
  // R11
  ignore_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && busy |=> $stable(cycles) && $stable(mode_err));
  // R1
  err_cost_chk: assert property (@(posedge clk) disable iff (!rst_n) mode_err |-> cycles == CNT_W'(2));
endmodule

bind cycle_cost_timer cycle_cost_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .mode_err(mode_err), .cycles(cycles)
);

// File: tb/cycle_cost_timer_test.sv
module cycle_cost_timer_test;
  logic        clk = 1'b0, rst_n = 1'b0, start = 1'b0, taken = 1'b0;
  logic [3:0]  op_cls = '0, mode = '0;
  logic [15:0] base_addr = '0, target = '0;
  logic [7:0]  index = '0;
  logic [3:0]  cycles;
  logic        busy, done, mode_err;
  int tests = 0, fails = 0;
  bit finished = 0;

  cycle_cost_timer uut (.*);

  always #10 clk = ~clk;

  function automatic int want(input int c, input int m, input logic [15:0] b,
                              input logic [7:0] x, input bit tk, input logic [15:0] t,
                              output bit err);
    logic [15:0] s;
    bit cr;
    int r;
    s = b + {8'h00, x};
    cr = s[15:8] != b[15:8];
    err = 0;
    r = -1;
    if (c == 0 || c == 1) begin
      if (m == 1 && c == 0) r = 2;
      else if (m == 2) r = 3;
      else if (m >= 3 && m <= 5) r = 4;
      else if (m == 8) r = 6;
      else if (m == 6 || m == 7) r = 4 + ((c == 1 || cr) ? 1 : 0);
      else if (m == 9) r = 5 + ((c == 1 || cr) ? 1 : 0);
    end else if (c == 2) begin
      if (m == 0) r = 2;
      else if (m == 2) r = 5;
      else if (m == 3 || m == 5) r = 6;
      else if (m == 6) r = 7;
    end else if (c >= 3 && c <= 7) begin
      if (m == 0) r = (c == 3) ? 2 : (c == 4) ? 3 : (c == 5) ? 4 : (c == 6) ? 6 : 7;
    end else if (c == 8) begin
      if (m == 11) r = !tk ? 2 : (t[15:8] != b[15:8]) ? 4 : 3;
    end else if (c == 9) begin
      if (m == 5) r = 3;
      else if (m == 10) r = 5;
    end else if (c == 10) begin
      if (m == 5) r = 6;
    end
    if (r < 0) begin
      err = 1;
      r = 2;
    end
    return r;
  endfunction

  function automatic string tag_of(input int c, input bit err);
    if (err) return "R1";
    case (c)
      0: return "R2";
      1: return "R4";
      2: return "R6";
      8: return "R8";
      9, 10: return "R9";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp, input string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_op(input int c, input int m, input logic [15:0] b, input logic [7:0] x,
                        input bit tk, input logic [15:0] t, input string req, input bit poke);
    bit eerr;
    int e, n;
    string rq;
    e = want(c, m, b, x, tk, t, eerr);
    rq = (req == "") ? tag_of(c, eerr) : req;
    op_cls = 4'(c); mode = 4'(m); base_addr = b; index = x; taken = tk; target = t;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(rq, int'(cycles), e, $sformatf("cost cls=%0d mode=%0d", c, m));
    check("R1", int'(mode_err), int'(eerr), $sformatf("error flag cls=%0d mode=%0d", c, m));
    n = 0;
    while (busy) begin
      n++;
      if (poke && n == 1) begin
        start = 1'b1; op_cls = 4'd7; mode = 4'd0;
      end else start = 1'b0;
      if (done != (n == e)) check("R10", int'(done), int'(n == e), $sformatf("done at busy cycle %0d", n));
      if (poke) check("R11", int'(cycles), e, "cost after ignored start");
      @(negedge clk);
    end
    start = 1'b0;
    check(poke ? "R11" : "R10", n, e, "busy length");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12", int'(busy), 0, "busy in reset");
    check("R12", int'(done), 0, "done in reset");
    check("R12", int'(cycles), 0, "cycles in reset");
    check("R12", int'(mode_err), 0, "mode_err in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R12", int'(busy), 0, "busy after reset release");

    // R3 page crossing on indexed non-zero-page modes
    run_op(0, 6, 16'h10FF, 8'h01, 0, 0, "R3", 0);
    run_op(0, 7, 16'h1000, 8'h01, 0, 0, "R3", 0);
    run_op(0, 9, 16'h20F0, 8'h10, 0, 0, "R3", 0);
    run_op(0, 6, 16'hFFF0, 8'h20, 0, 0, "R3", 0);
    // R4 store without crossing still pays
    run_op(1, 7, 16'h3000, 8'h02, 0, 0, "R4", 0);
    run_op(1, 9, 16'h3000, 8'h00, 0, 0, "R4", 0);
    // R5 wrapping modes ignore crossings
    run_op(0, 3, 16'h00F0, 8'h20, 0, 0, "R5", 0);
    run_op(1, 4, 16'h00FF, 8'hFF, 0, 0, "R5", 0);
    run_op(0, 8, 16'h00F8, 8'h10, 0, 0, "R5", 0);
    // R6 rmw absolute indexed fixed
    run_op(2, 6, 16'h40FF, 8'h01, 0, 0, "R6", 0);
    // R8 branches
    run_op(8, 11, 16'h5010, 0, 0, 16'h5120, "R8", 0);
    run_op(8, 11, 16'h5010, 0, 1, 16'h50F0, "R8", 0);
    run_op(8, 11, 16'h5010, 0, 1, 16'h4FF0, "R8", 0);
    // R11 starts during busy
    run_op(2, 6, 16'h1234, 8'h00, 0, 0, "R11", 1);
    run_op(3, 0, 16'h0000, 8'h00, 0, 0, "R11", 1);
    run_op(15, 3, 16'h0000, 8'h00, 0, 0, "R11", 1);

    // every class/mode pair, with and without a page crossing
    for (int c = 0; c < 16; c++)
      for (int m = 0; m < 16; m++) begin
        run_op(c, m, 16'h12F0, 8'h20, 1, 16'h1305, "", 0);
        run_op(c, m, 16'h12F0, 8'h05, 0, 16'h1280, "", 0);
      end

    // constrained random mix
    for (int k = 0; k < 600; k++) begin
      int c, m;
      logic [15:0] b, t;
      logic [7:0] x;
      c = ($urandom % 8 == 0) ? int'($urandom % 16) : int'($urandom % 11);
      m = int'($urandom % 12);
      b = 16'($urandom);
      x = ($urandom % 2) ? 8'($urandom) : 8'($urandom % 4);
      t = ($urandom % 2) ? b + 16'($urandom % 64) : 16'($urandom);
      run_op(c, m, b, x, 1'($urandom), t, "", k % 50 == 7);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule